// File: doc/BRIEF.md
# OTP fuse array command controller

A register-mapped front end for a one-time-programmable fuse array. The array model is built into the block. Software switches the array on through a power request bit and waits for a power status flag. It then starts an operation with a single control write, which holds the opcode and the target index. Three operations exist. A read copies a fuse word into a bank of shadow words that the bus can read. A program ORs a staged data word into a fuse word. A lock write ORs a staged data word into a small permanent-lock array.

Program operations on a word that the lock array marks as locked still run for their full duration, but they change nothing and raise a sticky fail flag. The fail flag is also raised when a command is refused. A command is refused when the array is unpowered, when an operation is already running, when the opcode is invalid or when the index is out of range. The shadow words can also be written directly from the bus. Such a write never reaches the fuses.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: Setting bit 0 of the config register (byte 0x000) makes status bit 5 rise `PWR_DLY` cycles after the write edge. Clearing bit 0 makes status bit 5 fall the same number of cycles after the write edge.
- R2: A write to the control register (0x004) uses bits 7:0 as the index and bits 9:8 as the opcode. The opcodes are 00 read, 01 program and 11 lock. Opcode 10 is refused and sets fail.
- R3: A read command holds busy for `RD_CYC` cycles. It then places the fuse word in the shadow slot at byte 0x200 + 4*index.
- R4: A program command holds busy for `PG_CYC` cycles. It then ORs the staging register (0x008, captured when the command is accepted) into the fuse word. A fuse bit that is 1 never returns to 0.
- R5: A program command to a locked word runs its full busy time, leaves the word unchanged and sets fail.
- R6: A lock command ORs the staging data into lock word `index` and lasts `PG_CYC` cycles. A word w below `UPPER_BASE` is locked when lock word w>>3 has a nonzero value at bits [2*(w&7)+1 : 2*(w&7)]. A word w at or above `UPPER_BASE` is locked when lock word (w>>4)+2 has bit (w&15) set.
- R7: A command is ignored and sets fail when it arrives while the array is unpowered or busy. The same applies when the read or program index is at least `NUM_WORDS`, or the lock index is at least the number of lock words.
- R8: The fail flag is sticky. It is cleared only when a command is accepted.
- R9: The status register (0x00C) holds the mode in bits 2:0 (0 idle, 1 read, 2 program, 3 lock), busy in bit 3, fail in bit 4 and powered in bit 5. All other bits read 0.
- R10: A bus write to a shadow slot changes that slot only. A later read command restores the slot from the unchanged fuse word.
- R11: Bus read data appears one cycle after the request. Unmapped addresses read 0. After reset all registers, shadow words and fuses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |

## Verification
The checker covers the following on every cycle:
- the powered flag changes only toward the current power request;
- busy rises only after a powered cycle, and fail is clear at that point;
- a control write during busy leaves fail set;
- the mode is nonzero while busy;
- no fuse bit ever falls.

Only the bench scenarios can show the following:
- the exact power and busy durations;
- shadow contents after reads;
- the OR accumulation of programs;
- the lock address and bit mapping for lower and upper words;
- the effect of opcode and range rejection.

// File: rtl/otp_cmd_pkg.sv
package otp_cmd_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned CMD_IDX_W = 8;
  localparam int unsigned OPC_LSB   = 8;

  typedef enum logic [1:0] {
    OPC_READ = 2'b00,
    OPC_PROG = 2'b01,
    OPC_BAD  = 2'b10,
    OPC_LOCK = 2'b11
  } opc_e;

  typedef enum logic [2:0] {
    MODE_IDLE = 3'd0,
    MODE_READ = 3'd1,
    MODE_PROG = 3'd2,
    MODE_LOCK = 3'd3
  } mode_e;

  localparam int unsigned ST_BUSY = 3;
  localparam int unsigned ST_FAIL = 4;
  localparam int unsigned ST_PWR  = 5;

  // word (addr >> 2) offsets
  localparam logic [9:0] WA_CFG    = 10'h000;
  localparam logic [9:0] WA_CTRL   = 10'h001;
  localparam logic [9:0] WA_WDATA  = 10'h002;
  localparam logic [9:0] WA_STAT   = 10'h003;
  localparam logic [9:0] WA_SHADOW = 10'h080;
endpackage

// File: rtl/otp_pwr_seq.sv
module otp_pwr_seq #(
  parameter int unsigned PWR_DLY = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pwr_o
);
  localparam int unsigned CW = $clog2(PWR_DLY + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pwr_o <= 1'b0;
    end else if (req_i == pwr_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(PWR_DLY - 1)) begin
      pwr_o <= req_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
  import otp_cmd_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 32,
  parameter int unsigned NUM_LOCK  = 4,
  parameter int unsigned RD_CYC    = 4,
  parameter int unsigned PG_CYC    = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_i,
  input  logic [1:0]           opc_i,
  input  logic [CMD_IDX_W-1:0] idx_i,
  input  logic [DW-1:0]        data_i,
  input  logic                 pwr_i,
  input  logic                 locked_i,
  output logic                 busy_o,
  output logic                 fail_o,
  output mode_e                mode_o,
  output logic [CMD_IDX_W-1:0] op_idx_o,
  output logic [DW-1:0]        op_data_o,
  output logic                 rd_commit_o,
  output logic                 prog_commit_o,
  output logic                 lock_commit_o
);
  localparam int unsigned MAXC = (RD_CYC > PG_CYC) ? RD_CYC : PG_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  opc_e          opc;
  logic          idx_ok, accept, finish;
  logic [CW-1:0] cnt_q;

  assign opc = opc_e'(opc_i);

  always_comb begin
    unique case (opc)
      OPC_LOCK: idx_ok = idx_i < CMD_IDX_W'(NUM_LOCK);
      OPC_BAD:  idx_ok = 1'b0;
      default:  idx_ok = idx_i < CMD_IDX_W'(NUM_WORDS);
    endcase
  end

  assign accept = issue_i & pwr_i & ~busy_o & idx_ok;
  assign finish = busy_o & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      fail_o    <= 1'b0;
      mode_o    <= MODE_IDLE;
      op_idx_o  <= '0;
      op_data_o <= '0;
      cnt_q     <= '0;
    end else if (accept) begin
      busy_o    <= 1'b1;
      fail_o    <= 1'b0;
      op_idx_o  <= idx_i;
      op_data_o <= data_i;
      unique case (opc)
        OPC_READ: begin mode_o <= MODE_READ; cnt_q <= CW'(RD_CYC - 1); end
        OPC_PROG: begin mode_o <= MODE_PROG; cnt_q <= CW'(PG_CYC - 1); end
        default:  begin mode_o <= MODE_LOCK; cnt_q <= CW'(PG_CYC - 1); end
      endcase
    end else begin
      if (finish) begin
        busy_o <= 1'b0;
        mode_o <= MODE_IDLE;
        if (mode_o == MODE_PROG && locked_i) fail_o <= 1'b1;
      end else if (busy_o) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (issue_i) fail_o <= 1'b1;  // refused command
    end
  end

  assign rd_commit_o   = finish & (mode_o == MODE_READ);
  assign prog_commit_o = finish & (mode_o == MODE_PROG) & ~locked_i;
  assign lock_commit_o = finish & (mode_o == MODE_LOCK);
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_cmd_pkg::*;
#(
  parameter int unsigned NUM_WORDS  = 32,
  parameter int unsigned NUM_LOCK   = 4,
  parameter int unsigned UPPER_BASE = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CMD_IDX_W-1:0]    idx_i,
  input  logic [DW-1:0]           data_i,
  input  logic                    prog_i,
  input  logic                    lock_i,
  output logic [DW-1:0]           rd_word_o,
  output logic                    locked_o,
  output logic [NUM_WORDS*DW-1:0] fuse_flat_o
);
  logic [DW-1:0]        fuse_q [NUM_WORDS];
  logic [DW-1:0]        lock_q [NUM_LOCK];
  logic [CMD_IDX_W-1:0] lk_addr;
  logic [DW-1:0]        lk_mask, lk_word;

  // fuse and lock bits only ever go 0 -> 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NUM_WORDS; g++) fuse_q[g] <= '0;
      for (int k = 0; k < NUM_LOCK; k++)  lock_q[k] <= '0;
    end else begin
      for (int g = 0; g < NUM_WORDS; g++)
        if (prog_i && idx_i == CMD_IDX_W'(g)) fuse_q[g] <= fuse_q[g] | data_i;
      for (int k = 0; k < NUM_LOCK; k++)
        if (lock_i && idx_i == CMD_IDX_W'(k)) lock_q[k] <= lock_q[k] | data_i;
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_flat
    assign fuse_flat_o[g*DW +: DW] = fuse_q[g];
  end

  always_comb begin
    if (idx_i < CMD_IDX_W'(UPPER_BASE)) begin
      lk_addr = idx_i >> 3;
      lk_mask = DW'(2'b11) << {idx_i[2:0], 1'b0};
    end else begin
      lk_addr = (idx_i >> 4) + CMD_IDX_W'(2);
      lk_mask = DW'(1'b1) << idx_i[3:0];
    end
    lk_word = '0;
    for (int k = 0; k < NUM_LOCK; k++)
      if (lk_addr == CMD_IDX_W'(k)) lk_word = lock_q[k];
    locked_o = |(lk_word & lk_mask);
  end

  always_comb begin
    rd_word_o = '0;
    for (int g = 0; g < NUM_WORDS; g++)
      if (idx_i == CMD_IDX_W'(g)) rd_word_o = fuse_q[g];
  end
endmodule

// File: rtl/otp_shadow_bank.sv
module otp_shadow_bank
  import otp_cmd_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 32,
  parameter int unsigned IW        = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [IW-1:0]        wr_idx_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic                 load_i,
  input  logic [CMD_IDX_W-1:0] load_idx_i,
  input  logic [DW-1:0]        load_data_i,
  input  logic [IW-1:0]        rd_idx_i,
  output logic [DW-1:0]        rd_data_o
);
  logic [DW-1:0] sh_q [NUM_WORDS];

  // array load wins over a same-cycle bus write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NUM_WORDS; g++) sh_q[g] <= '0;
    end else begin
      for (int g = 0; g < NUM_WORDS; g++) begin
        if (load_i && load_idx_i == CMD_IDX_W'(g)) sh_q[g] <= load_data_i;
        else if (wr_i && wr_idx_i == IW'(g))       sh_q[g] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int g = 0; g < NUM_WORDS; g++)
      if (rd_idx_i == IW'(g)) rd_data_o = sh_q[g];
  end
endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
  import otp_cmd_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned NUM_WORDS  = 32,
  parameter int unsigned UPPER_BASE = 16,
  parameter int unsigned RD_CYC     = 4,
  parameter int unsigned PG_CYC     = 10,
  parameter int unsigned PWR_DLY    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o
);
  localparam int unsigned WA_W     = AW - 2;
  localparam int unsigned IW       = $clog2(NUM_WORDS);
  localparam int unsigned NUM_LOCK = (NUM_WORDS >> 4) + 2;

  logic [WA_W-1:0]      word_addr, sh_off;
  logic                 hit_cfg, hit_ctrl, hit_wdata, hit_stat, hit_sh;
  logic                 bus_wr, bus_rd, ctrl_wr;
  logic                 cfg_pwr_q, pwr;
  logic [DW-1:0]        wdata_q, status, sh_rdata, rd_word;
  logic                 busy, fail, locked;
  mode_e                mode;
  logic [CMD_IDX_W-1:0] op_idx;
  logic [DW-1:0]        op_data;
  logic                 rd_commit, prog_commit, lock_commit;
  logic [NUM_WORDS*DW-1:0] fuse_flat;

  assign word_addr = bus_addr_i[AW-1:2];
  assign sh_off    = word_addr - WA_W'(WA_SHADOW);
  assign hit_cfg   = word_addr == WA_W'(WA_CFG);
  assign hit_ctrl  = word_addr == WA_W'(WA_CTRL);
  assign hit_wdata = word_addr == WA_W'(WA_WDATA);
  assign hit_stat  = word_addr == WA_W'(WA_STAT);
  assign hit_sh    = (word_addr >= WA_W'(WA_SHADOW)) && (sh_off < WA_W'(NUM_WORDS));

  assign bus_wr  = bus_req_i & bus_we_i;
  assign bus_rd  = bus_req_i & ~bus_we_i;
  assign ctrl_wr = bus_wr & hit_ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_pwr_q <= 1'b0;
      wdata_q   <= '0;
    end else begin
      if (bus_wr && hit_cfg)   cfg_pwr_q <= bus_wdata_i[0];
      if (bus_wr && hit_wdata) wdata_q   <= bus_wdata_i;
    end
  end

  otp_pwr_seq #(.PWR_DLY(PWR_DLY)) u_pwr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (cfg_pwr_q),
    .pwr_o (pwr)
  );

  otp_cmd_seq #(
    .NUM_WORDS(NUM_WORDS),
    .NUM_LOCK (NUM_LOCK),
    .RD_CYC   (RD_CYC),
    .PG_CYC   (PG_CYC)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_i      (ctrl_wr),
    .opc_i        (bus_wdata_i[OPC_LSB +: 2]),
    .idx_i        (bus_wdata_i[CMD_IDX_W-1:0]),
    .data_i       (wdata_q),
    .pwr_i        (pwr),
    .locked_i     (locked),
    .busy_o       (busy),
    .fail_o       (fail),
    .mode_o       (mode),
    .op_idx_o     (op_idx),
    .op_data_o    (op_data),
    .rd_commit_o  (rd_commit),
    .prog_commit_o(prog_commit),
    .lock_commit_o(lock_commit)
  );

  otp_fuse_array #(
    .NUM_WORDS (NUM_WORDS),
    .NUM_LOCK  (NUM_LOCK),
    .UPPER_BASE(UPPER_BASE)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (op_idx),
    .data_i     (op_data),
    .prog_i     (prog_commit),
    .lock_i     (lock_commit),
    .rd_word_o  (rd_word),
    .locked_o   (locked),
    .fuse_flat_o(fuse_flat)
  );

  otp_shadow_bank #(.NUM_WORDS(NUM_WORDS), .IW(IW)) u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_wr & hit_sh),
    .wr_idx_i   (sh_off[IW-1:0]),
    .wr_data_i  (bus_wdata_i),
    .load_i     (rd_commit),
    .load_idx_i (op_idx),
    .load_data_i(rd_word),
    .rd_idx_i   (sh_off[IW-1:0]),
    .rd_data_o  (sh_rdata)
  );

  always_comb begin
    status          = '0;
    status[2:0]     = mode;
    status[ST_BUSY] = busy;
    status[ST_FAIL] = fail;
    status[ST_PWR]  = pwr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o <= '0;
    end else if (bus_rd) begin
      if (hit_cfg)        bus_rdata_o <= DW'(cfg_pwr_q);
      else if (hit_wdata) bus_rdata_o <= wdata_q;
      else if (hit_stat)  bus_rdata_o <= status;
      else if (hit_sh)    bus_rdata_o <= sh_rdata;
      else                bus_rdata_o <= '0;
    end
  end
endmodule

// File: rtl/otp_cmd_ctrl_chk.sv
module otp_cmd_ctrl_chk #(
  parameter int unsigned FLAT_W = 1024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_wr_i,
  input logic              pwr_i,
  input logic              pwr_req_i,
  input logic              busy_i,
  input logic              fail_i,
  input logic [2:0]        mode_i,
  input logic [FLAT_W-1:0] fuse_flat_i
);
  assert_pwr_toward_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pwr_i) |-> (pwr_i == $past(pwr_req_i)));

  assert_fuse_no_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(fuse_flat_i) & ~fuse_flat_i) == '0));

  assert_start_needs_pwr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(pwr_i));

  assert_busy_cmd_fails_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && busy_i) |=> fail_i);

  assert_accept_clears_fail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !fail_i);

  assert_busy_mode_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (mode_i != 3'd0));
endmodule

bind otp_cmd_ctrl otp_cmd_ctrl_chk #(.FLAT_W(NUM_WORDS * 32)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_wr_i  (ctrl_wr),
  .pwr_i      (pwr),
  .pwr_req_i  (cfg_pwr_q),
  .busy_i     (busy),
  .fail_i     (fail),
  .mode_i     (mode),
  .fuse_flat_i(fuse_flat)
);

// File: tb/otp_cmd_ctrl_tb_top.sv
module otp_cmd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 32, UB = 16, RD = 4, PG = 10, PD = 6;
  localparam logic [11:0] A_CFG = 12'h000, A_CTRL = 12'h004, A_WD = 12'h008, A_ST = 12'h00C;
  localparam logic [31:0] S_PWR = 32'h20, S_FAIL = 32'h10, S_BUSY = 32'h08;
  localparam logic [31:0] OP_RD = 32'h000, OP_PG = 32'h100, OP_BAD = 32'h200, OP_LK = 32'h300;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_q = 1'b0;
  logic        done = 1'b0;
  int          checks = 0, bad = 0;
  sb_item_t    sb_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  otp_cmd_ctrl #(.NUM_WORDS(NW), .UPPER_BASE(UB), .RD_CYC(RD), .PG_CYC(PG), .PWR_DLY(PD)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_req_i  (req),
    .bus_we_i   (we),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata)
  );

  function automatic logic [11:0] sh(input int i);
    return 12'h200 + 12'(4 * i);
  endfunction

  // lock address / data per R6
  function automatic logic [31:0] lk_addr(input int w);
    return (w < UB) ? 32'(w >> 3) : 32'((w >> 4) + 2);
  endfunction
  function automatic logic [31:0] lk_data(input int w);
    return (w < UB) ? (32'h3 << (2 * (w & 7))) : (32'h1 << (w & 15));
  endfunction

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input logic [31:0] m, input string tag);
    sb_q.push_back('{exp: e, mask: m, tag: tag});
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic run_cmd(input logic [31:0] c);
    bus_wr(A_CTRL, c);
    repeat (PG + 1) @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) rd_q <= req & ~we;

  always @(negedge clk) begin
    if (rd_q) begin
      sb_item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard: read seen with no expectation, got %h exp none", rdata);
      end else begin
        it = sb_q.pop_front();
        if ((rdata & it.mask) != (it.exp & it.mask)) begin
          bad++;
          $display("FAIL %s: got %h exp %h", it.tag, rdata & it.mask, it.exp & it.mask);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    bus_rd(A_CFG, 32'h0, '1, "R11 cfg after reset");
    bus_rd(A_ST, 32'h0, '1, "R11 R9 status after reset");
    bus_rd(sh(7), 32'h0, '1, "R11 shadow after reset");
    bus_rd(12'h100, 32'h0, '1, "R11 unmapped reads zero");

    // R7 unpowered command
    bus_wr(A_CTRL, OP_RD | 32'd3);
    bus_rd(A_ST, S_FAIL, '1, "R7 unpowered command refused");

    // R1 power-up timing
    bus_wr(A_CFG, 32'h1);
    repeat (PD - 1) @(negedge clk);
    bus_rd(A_ST, 32'h0, S_PWR, "R1 not yet powered");
    bus_rd(A_ST, S_PWR, S_PWR, "R1 powered after delay");

    // R4 program and busy length; R8 fail cleared on accept
    bus_wr(A_WD, 32'h0000_00F0);
    bus_wr(A_CTRL, OP_PG | 32'd7);
    repeat (PG - 1) @(negedge clk);
    bus_rd(A_ST, S_PWR | S_BUSY | 32'd2, '1, "R4 R8 R9 busy last program cycle");
    bus_rd(A_ST, S_PWR, '1, "R4 busy cleared");

    // R3 read command, busy length, shadow copy
    bus_wr(A_CTRL, OP_RD | 32'd7);
    repeat (RD - 1) @(negedge clk);
    bus_rd(A_ST, S_PWR | S_BUSY | 32'd1, '1, "R3 R9 busy last read cycle");
    bus_rd(A_ST, S_PWR, '1, "R3 read busy cleared");
    bus_rd(sh(7), 32'h0000_00F0, '1, "R3 shadow loaded");

    // R4 OR accumulation, no clearing
    bus_wr(A_WD, 32'h0000_000F);
    run_cmd(OP_PG | 32'd7);
    bus_wr(A_WD, 32'h0);
    run_cmd(OP_PG | 32'd7);
    run_cmd(OP_RD | 32'd7);
    bus_rd(sh(7), 32'h0000_00FF, '1, "R4 programs OR together");

    // R10 direct shadow write does not touch fuses
    bus_wr(sh(7), 32'hDEAD_BEEF);
    bus_rd(sh(7), 32'hDEAD_BEEF, '1, "R10 shadow direct write");
    run_cmd(OP_RD | 32'd7);
    bus_rd(sh(7), 32'h0000_00FF, '1, "R10 fuse unchanged by shadow write");

    // R7 command while busy
    bus_wr(A_WD, 32'h5);
    bus_wr(A_CTRL, OP_PG | 32'd1);
    bus_wr(A_CTRL, OP_RD | 32'd2);
    repeat (PG + 1) @(negedge clk);
    bus_rd(A_ST, S_PWR | S_FAIL, '1, "R7 busy command refused, R8 fail sticky");

    // R8 accepted command clears fail
    run_cmd(OP_RD | 32'd1);
    bus_rd(A_ST, S_PWR, '1, "R8 fail cleared by accepted command");
    bus_rd(sh(1), 32'h5, '1, "R7 first program kept");

    // R2 invalid opcode, R7 range
    bus_wr(A_CTRL, OP_BAD | 32'd1);
    bus_rd(A_ST, S_PWR | S_FAIL, '1, "R2 opcode 10 refused");
    run_cmd(OP_RD | 32'd1);
    bus_wr(A_CTRL, OP_RD | 32'd40);
    bus_rd(A_ST, S_PWR | S_FAIL, '1, "R7 read index out of range");
    run_cmd(OP_RD | 32'd1);
    bus_wr(A_CTRL, OP_LK | 32'd5);
    bus_rd(A_ST, S_PWR | S_FAIL, '1, "R7 lock index out of range");

    // R6 lower lock (word 5), R5 locked program
    bus_wr(A_WD, lk_data(5));
    run_cmd(OP_LK | lk_addr(5));
    bus_rd(A_ST, S_PWR, '1, "R6 lock command completes");
    bus_wr(A_WD, 32'h1);
    bus_wr(A_CTRL, OP_PG | 32'd5);
    repeat (PG - 1) @(negedge clk);
    bus_rd(A_ST, S_PWR | S_BUSY | 32'd2, '1, "R5 locked program runs full time");
    bus_rd(A_ST, S_PWR | S_FAIL, '1, "R5 locked program fails");
    run_cmd(OP_RD | 32'd5);
    bus_rd(sh(5), 32'h0, '1, "R5 locked word unchanged");
    bus_wr(A_WD, 32'h44);
    run_cmd(OP_PG | 32'd4);
    bus_rd(A_ST, S_PWR, '1, "R6 neighbour word 4 not locked");
    run_cmd(OP_RD | 32'd4);
    bus_rd(sh(4), 32'h44, '1, "R6 word 4 programmed");

    // R6 upper lock (word 20)
    bus_wr(A_WD, lk_data(20));
    run_cmd(OP_LK | lk_addr(20));
    bus_wr(A_WD, 32'h3);
    run_cmd(OP_PG | 32'd20);
    bus_rd(A_ST, S_PWR | S_FAIL, '1, "R6 R5 upper word 20 locked");
    run_cmd(OP_PG | 32'd21);
    bus_rd(A_ST, S_PWR, '1, "R6 upper word 21 not locked");
    run_cmd(OP_RD | 32'd21);
    bus_rd(sh(21), 32'h3, '1, "R6 word 21 programmed");

    // R1 power-down timing, R7 after power-down
    bus_wr(A_CFG, 32'h0);
    repeat (PD - 1) @(negedge clk);
    bus_rd(A_ST, S_PWR, S_PWR, "R1 still powered before delay");
    bus_rd(A_ST, 32'h0, S_PWR, "R1 unpowered after delay");
    bus_wr(A_CTRL, OP_RD | 32'd4);
    bus_rd(A_ST, S_FAIL, '1, "R7 command after power-down refused");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule